// File: doc/BRIEF.md
# Smart Panel Command Sequencer

This block runs a stream of 12-bit command words against a display panel that keeps its own frame memory and is driven over an 8-bit parallel bus of the 8080 kind: an active-low chip select, separate active-low write and read strobes, and an address/data select line (A0). Each word is taken over a valid/ready handshake and carries a 3-bit opcode, the A0 level and an 8-bit payload. Besides panel reads and writes, the stream can stall until the next vertical sync edge, pause for a whole number of milliseconds, raise an interrupt, or ask the frame DMA (outside this block) to start a frame transfer.

Panel reads finish by latching an 11-bit status word: the byte read, the A0 level the read used, a valid flag and a flag that tells whether another command word was already waiting when the byte arrived. Two sticky event flags (in-stream interrupt, read complete) are each masked into a single interrupt line. Strobe setup, pulse and hold lengths come from configuration inputs, and the millisecond time base is a count of system clocks set by a parameter.

Top module: `panel_cmd_seq`

## Requirements
- R1: Word layout is op = cmd_word[11:9], A0 = cmd_word[8], payload = cmd_word[7:0]. Opcode 1 performs one bus write of the payload with bus_a0 equal to A0 (A0=0 command byte, A0=1 data byte); bus_dout holds the payload while bus_wr_n is low.
- R2: A bus access holds bus_cs_n low for (S+1)+(P+1)+(H+1) cycles, where S, P, H are cfg_setup, cfg_pulse, cfg_hold; the strobe is low only during the middle P+1 cycles; bus_a0 and bus_dout do not change while the strobe falls; cmd_ready stays low for exactly those cycles.
- R3: Opcode 0 performs one read (A0=0 status register, A0=1 frame memory) with bus_rd_n low P+1 cycles; bus_din is sampled in the last low cycle and rd_status becomes {continue[10], ok[9]=1, A0[8], data[7:0]}.
- R4: The continue bit of rd_status equals cmd_valid in the cycle the read byte is sampled.
- R5: Opcode 2 with A0=1 pulses frame_start high for one cycle, the cycle after acceptance, without bus activity or stall; opcode 2 with A0=0 does nothing.
- R6: Opcode 3 holds cmd_ready low until a rising edge of vsync seen after acceptance; with SYNC_STAGES=2 cmd_ready returns high in the third cycle after vsync rises. A vsync already high at acceptance does not end the wait.
- R7: Opcode 6 with payload N holds cmd_ready low for N*CLKS_PER_MS+1 cycles; N=0 takes one cycle.
- R8: Opcode 5 sets flags[0]; every completed read sets flags[1]; a flag stays set until its bit of flag_clr is high; irq is high when any flag is set and its irq_mask bit is low.
- R9: Opcodes 4 and 7 cause no bus activity, no stall and no flag change.
- R10: cmd_ready is high only when the sequencer is idle; a word presented while it is busy has no effect.
- R11: After reset cmd_ready is high, all strobes and chip select are inactive (high), flags, irq and rd_status are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_word | input | 12 | Opcode, A0 and payload |
| cmd_ready | output | 1 | Sequencer idle, word taken when valid |
| cfg_setup | input | CNT_W | Setup cycles minus one |
| cfg_pulse | input | CNT_W | Strobe-low cycles minus one |
| cfg_hold | input | CNT_W | Hold cycles minus one |
| vsync | input | 1 | Panel vertical sync (asynchronous) |
| flag_clr | input | 2 | Clear flags (bit0 interrupt, bit1 read) |
| irq_mask | input | 2 | Mask bits for the two flags |
| bus_cs_n | output | 1 | Panel chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_a0 | output | 1 | Address/data select |
| bus_dout | output | 8 | Write data |
| bus_oe | output | 1 | Write data drive enable |
| bus_din | input | 8 | Read data from panel |
| frame_start | output | 1 | One-cycle frame transfer request |
| rd_status | output | 11 | Latched read result and flags |
| flags | output | 2 | Sticky event flags |
| irq | output | 1 | Masked interrupt |

## Verification
The decoder is driven with every opcode under both A0 levels where A0 matters, so a write of a command byte, a write of a data byte, both read kinds, the frame request and its inert A0=0 twin are each distinguished by strobe counts, A0 level, payload and stall length. Reads use different panel bytes so the latched data and source bit cannot be confused. Strobe timing is tried with three setup/pulse/hold mixes, which separates an off-by-one in any phase. Delays of zero, one and two milliseconds, vsync waits entered with vsync low and high, a read with a following word already waiting, and a word offered while busy cover the stall and handshake corners.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [2:0] {
      OP_READ  = 3'd0,
      OP_WRITE = 3'd1,
      OP_FRAME = 3'd2,
      OP_VSYNC = 3'd3,
      OP_NOP   = 3'd4,
      OP_IRQ   = 3'd5,
      OP_DELAY = 3'd6,
      OP_RSVD  = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_BUS,
      SQ_VWAIT,
      SQ_DELAY
   } sq_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_PULSE,
      PH_HOLD
   } ph_e;

   typedef struct packed {
      op_e        op;
      logic       a0;
      logic [7:0] pay;
   } word_t;

   typedef struct packed {
      logic       cont;
      logic       ok;
      logic       a0;
      logic [7:0] data;
   } rdstat_t;

endpackage

// File: rtl/pcs_strobe.sv
module pcs_strobe
   import pcs_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_read,
   input  logic [CNT_W-1:0] setup_cyc,
   input  logic [CNT_W-1:0] pulse_cyc,
   input  logic [CNT_W-1:0] hold_cyc,
   output logic             cs_n,
   output logic             wr_n,
   output logic             rd_n,
   output logic             capture,
   output logic             done
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   ph_e              ph;
   logic [CNT_W-1:0] cnt;
   logic             rd_q;
   logic             last;

   assign last = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= PH_IDLE;
         cnt  <= '0;
         rd_q <= 1'b0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               if (start) begin
                  ph   <= PH_SETUP;
                  cnt  <= setup_cyc;
                  rd_q <= is_read;
               end
            end
            PH_SETUP: begin
               if (last) begin
                  ph  <= PH_PULSE;
                  cnt <= pulse_cyc;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            PH_PULSE: begin
               if (last) begin
                  ph  <= PH_HOLD;
                  cnt <= hold_cyc;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            PH_HOLD: begin
               if (last) begin
                  ph <= PH_IDLE;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign cs_n    = (ph == PH_IDLE);
   assign wr_n    = !((ph == PH_PULSE) && !rd_q);
   assign rd_n    = !((ph == PH_PULSE) && rd_q);
   assign capture = (ph == PH_PULSE) && last && rd_q;
   assign done    = (ph == PH_HOLD) && last;

   assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!wr_n && !rd_n));

   assert_release_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (cs_n && wr_n && rd_n));

endmodule

// File: rtl/pcs_ms_timer.sv
module pcs_ms_timer #(
   parameter int CLKS_PER_MS = 125000,
   parameter int MS_W        = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [MS_W-1:0] ms_in,
   output logic            zero
);

   localparam int TICK_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;

   logic [MS_W-1:0] ms_left;
   logic            tick;
   logic            run;

   assign run = (ms_left != '0);

   generate
      if (CLKS_PER_MS == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_div
         localparam logic [TICK_W-1:0] LAST = TICK_W'(CLKS_PER_MS - 1);
         logic [TICK_W-1:0] sub;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sub <= '0;
            end else if (load) begin
               sub <= '0;
            end else if (run) begin
               sub <= (sub == LAST) ? '0 : sub + TICK_W'(1);
            end
         end

         assign tick = (sub == LAST);

         assert_sub_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
            sub <= LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_left <= '0;
      end else if (load) begin
         ms_left <= ms_in;
      end else if (run && tick) begin
         ms_left <= ms_left - MS_W'(1);
      end
   end

   assign zero = !run;

   assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && run) |=> (ms_left <= $past(ms_left)));

endmodule

// File: rtl/pcs_rd_capture.sv
module pcs_rd_capture
   import pcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       capture,
   input  logic       a0,
   input  logic [7:0] din,
   input  logic       cont,
   input  logic       clr,
   output rdstat_t    stat,
   output logic       flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         flag <= 1'b0;
      end else begin
         if (capture) begin
            stat.cont <= cont;
            stat.ok   <= 1'b1;
            stat.a0   <= a0;
            stat.data <= din;
         end
         if (capture) begin
            flag <= 1'b1;
         end else if (clr) begin
            flag <= 1'b0;
         end
      end
   end

   assert_flag_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (flag && stat.ok));

endmodule

// File: rtl/panel_cmd_seq.sv
module panel_cmd_seq
   import pcs_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int CLKS_PER_MS = 125000,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [11:0]      cmd_word,
   output logic             cmd_ready,
   input  logic [CNT_W-1:0] cfg_setup,
   input  logic [CNT_W-1:0] cfg_pulse,
   input  logic [CNT_W-1:0] cfg_hold,
   input  logic             vsync,
   input  logic [1:0]       flag_clr,
   input  logic [1:0]       irq_mask,
   output logic             bus_cs_n,
   output logic             bus_wr_n,
   output logic             bus_rd_n,
   output logic             bus_a0,
   output logic [7:0]       bus_dout,
   output logic             bus_oe,
   input  logic [7:0]       bus_din,
   output logic             frame_start,
   output logic [10:0]      rd_status,
   output logic [1:0]       flags,
   output logic             irq
);

   localparam int PAY_W = $bits(word_t) - 4;

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16");
      end
      if (CLKS_PER_MS < 1) begin : g_bad_ms
         $error("CLKS_PER_MS must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   word_t            w_in;
   sq_e              sq;
   logic             accept;
   logic             is_bus_op;
   logic             stb_done;
   logic             stb_cap;
   logic             tmr_zero;
   logic             vs_s;
   logic             vs_prev;
   logic             vs_rise;
   logic             a0_q;
   logic             rd_q;
   logic [PAY_W-1:0] dout_q;
   logic             frame_q;
   logic             cmd_flag;
   logic             rd_flag;
   rdstat_t          stat;

   assign w_in      = word_t'(cmd_word);
   assign cmd_ready = (sq == SQ_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign is_bus_op = (w_in.op == OP_READ) || (w_in.op == OP_WRITE);

   // vsync synchroniser: depth picked by parameter
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign vs_s = vsync;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '0;
            end else begin
               sh[0] <= vsync;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sh[i] <= sh[i-1];
               end
            end
         end
         assign vs_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_prev <= 1'b0;
      end else begin
         vs_prev <= vs_s;
      end
   end

   assign vs_rise = vs_s && !vs_prev;

   // command decoder and sequencing state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq       <= SQ_IDLE;
         a0_q     <= 1'b0;
         rd_q     <= 1'b0;
         dout_q   <= '0;
         frame_q  <= 1'b0;
         cmd_flag <= 1'b0;
      end else begin
         frame_q <= accept && (w_in.op == OP_FRAME) && w_in.a0;

         if (accept && (w_in.op == OP_IRQ)) begin
            cmd_flag <= 1'b1;
         end else if (flag_clr[0]) begin
            cmd_flag <= 1'b0;
         end

         if (accept && is_bus_op) begin
            a0_q <= w_in.a0;
            rd_q <= (w_in.op == OP_READ);
            if (w_in.op == OP_WRITE) begin
               dout_q <= w_in.pay;
            end
         end

         unique case (sq)
            SQ_IDLE: begin
               if (accept) begin
                  if (is_bus_op) begin
                     sq <= SQ_BUS;
                  end else if (w_in.op == OP_VSYNC) begin
                     sq <= SQ_VWAIT;
                  end else if (w_in.op == OP_DELAY) begin
                     sq <= SQ_DELAY;
                  end
               end
            end
            SQ_BUS:   if (stb_done) sq <= SQ_IDLE;
            SQ_VWAIT: if (vs_rise)  sq <= SQ_IDLE;
            SQ_DELAY: if (tmr_zero) sq <= SQ_IDLE;
            default:  sq <= SQ_IDLE;
         endcase
      end
   end

   pcs_strobe #(
      .CNT_W (CNT_W)
   ) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept && is_bus_op),
      .is_read   (w_in.op == OP_READ),
      .setup_cyc (cfg_setup),
      .pulse_cyc (cfg_pulse),
      .hold_cyc  (cfg_hold),
      .cs_n      (bus_cs_n),
      .wr_n      (bus_wr_n),
      .rd_n      (bus_rd_n),
      .capture   (stb_cap),
      .done      (stb_done)
   );

   pcs_ms_timer #(
      .CLKS_PER_MS (CLKS_PER_MS),
      .MS_W        (PAY_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept && (w_in.op == OP_DELAY)),
      .ms_in (w_in.pay),
      .zero  (tmr_zero)
   );

   pcs_rd_capture u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (stb_cap),
      .a0      (a0_q),
      .din     (bus_din),
      .cont    (cmd_valid),
      .clr     (flag_clr[1]),
      .stat    (stat),
      .flag    (rd_flag)
   );

   assign bus_a0      = a0_q;
   assign bus_dout    = dout_q;
   assign bus_oe      = (sq == SQ_BUS) && !rd_q;
   assign frame_start = frame_q;
   assign rd_status   = stat;
   assign flags       = {rd_flag, cmd_flag};
   assign irq         = |(flags & ~irq_mask);

   assert_a0_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_wr_n) |-> ($stable(bus_a0) && $stable(bus_dout) && !bus_cs_n));

   assert_idle_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (bus_cs_n && bus_wr_n && bus_rd_n));

   assert_frame_from_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> $past(cmd_ready && cmd_valid));

   assert_vwait_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((sq == SQ_VWAIT) && !vs_rise) |=> !cmd_ready);

endmodule

// File: tb/panel_cmd_seq_tb.sv
module panel_cmd_seq_tb;

   localparam int CNT_W = 4;
   localparam int KMS   = 4;
   localparam int NV    = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [11:0]      cmd_word = '0;
   logic             cmd_ready;
   logic [CNT_W-1:0] cfg_setup = 4'd1;
   logic [CNT_W-1:0] cfg_pulse = 4'd2;
   logic [CNT_W-1:0] cfg_hold  = 4'd0;
   logic             vsync = 1'b0;
   logic [1:0]       flag_clr = 2'b00;
   logic [1:0]       irq_mask = 2'b11;
   logic             bus_cs_n, bus_wr_n, bus_rd_n, bus_a0, bus_oe;
   logic [7:0]       bus_dout;
   logic [7:0]       bus_din = 8'h00;
   logic             frame_start;
   logic [10:0]      rd_status;
   logic [1:0]       flags;
   logic             irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   panel_cmd_seq #(
      .CNT_W       (CNT_W),
      .CLKS_PER_MS (KMS),
      .SYNC_STAGES (2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .cmd_ready(cmd_ready), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
      .cfg_hold(cfg_hold), .vsync(vsync), .flag_clr(flag_clr), .irq_mask(irq_mask),
      .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_a0(bus_a0),
      .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
      .frame_start(frame_start), .rd_status(rd_status), .flags(flags), .irq(irq)
   );

   typedef struct packed {
      logic [11:0] word;
      logic [7:0]  din;
      logic [7:0]  busy;
      logic [3:0]  wr;
      logic [3:0]  rd;
      logic        a0;
      logic [7:0]  dat;
      logic [1:0]  frm;
      logic [10:0] stat;
      logic        chk_stat;
   } vec_t;

   // timing during the table: setup 1, pulse 2, hold 0 -> 6 busy cycles, strobe 3
   localparam vec_t VECS [NV] = '{
      '{12'h23C, 8'h00, 8'd6, 4'd3, 4'd0, 1'b0, 8'h3C, 2'd0, 11'h000, 1'b0}, // R1 command byte
      '{12'h3C5, 8'h00, 8'd6, 4'd3, 4'd0, 1'b1, 8'hC5, 2'd0, 11'h000, 1'b0}, // R1 data byte
      '{12'h000, 8'hA5, 8'd6, 4'd0, 4'd3, 1'b0, 8'h00, 2'd0, 11'h2A5, 1'b1}, // R3 status read
      '{12'h100, 8'h3C, 8'd6, 4'd0, 4'd3, 1'b1, 8'h00, 2'd0, 11'h33C, 1'b1}, // R3 frame read
      '{12'h500, 8'h00, 8'd0, 4'd0, 4'd0, 1'b0, 8'h00, 2'd1, 11'h000, 1'b0}, // R5 frame start
      '{12'h400, 8'h00, 8'd0, 4'd0, 4'd0, 1'b0, 8'h00, 2'd0, 11'h000, 1'b0}, // R5 A0=0 inert
      '{12'h8FF, 8'h00, 8'd0, 4'd0, 4'd0, 1'b0, 8'h00, 2'd0, 11'h000, 1'b0}, // R9 nop
      '{12'hE5A, 8'h00, 8'd0, 4'd0, 4'd0, 1'b0, 8'h00, 2'd0, 11'h000, 1'b0}, // R9 op7
      '{12'hC00, 8'h00, 8'd1, 4'd0, 4'd0, 1'b0, 8'h00, 2'd0, 11'h000, 1'b0}, // R7 zero delay
      '{12'hC01, 8'h00, 8'd5, 4'd0, 4'd0, 1'b0, 8'h00, 2'd0, 11'h000, 1'b0}, // R7 1 ms
      '{12'hC02, 8'h00, 8'd9, 4'd0, 4'd0, 1'b0, 8'h00, 2'd0, 11'h000, 1'b0}, // R7 2 ms
      '{12'hA00, 8'h00, 8'd0, 4'd0, 4'd0, 1'b0, 8'h00, 2'd0, 11'h000, 1'b0}  // R8 irq op
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [11:0] wd, output int busy, output int wr,
                          output int rd, output int frm, output logic a0s,
                          output logic [7:0] ds);
      busy = 0; wr = 0; rd = 0; frm = 0; a0s = 1'b0; ds = 8'h00;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_word  = wd;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!cmd_ready && busy < 4000) begin
         busy++;
         if (!bus_wr_n) begin wr++; a0s = bus_a0; ds = bus_dout; end
         if (!bus_rd_n) begin rd++; a0s = bus_a0; end
         frm += int'(frame_start);
         @(negedge clk);
      end
      frm += int'(frame_start);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int busy, wr, rd, frm, cnt;
      logic a0s;
      logic [7:0] ds;

      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 ready", int'(cmd_ready), 1);
      chk("R11 cs_n", int'(bus_cs_n), 1);
      chk("R11 wr_n/rd_n", int'({bus_wr_n, bus_rd_n}), 3);
      chk("R11 flags", int'(flags), 0);
      chk("R11 irq", int'(irq), 0);
      chk("R11 rd_status", int'(rd_status), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 ready after release", int'(cmd_ready), 1);

      for (int i = 0; i < NV; i++) begin
         bus_din = VECS[i].din;
         run_cmd(VECS[i].word, busy, wr, rd, frm, a0s, ds);
         chk($sformatf("R2/R7/R9 busy v%0d", i), busy, int'(VECS[i].busy));
         chk($sformatf("R1 write strobes v%0d", i), wr, int'(VECS[i].wr));
         chk($sformatf("R3 read strobes v%0d", i), rd, int'(VECS[i].rd));
         chk($sformatf("R5 frame pulses v%0d", i), frm, int'(VECS[i].frm));
         if (wr + rd > 0) chk($sformatf("R1 a0 v%0d", i), int'(a0s), int'(VECS[i].a0));
         if (wr > 0) chk($sformatf("R1 dout v%0d", i), int'(ds), int'(VECS[i].dat));
         if (VECS[i].chk_stat) chk($sformatf("R3 status v%0d", i), int'(rd_status), int'(VECS[i].stat));
      end

      // R8 flags and masking (reads set bit1, irq op set bit0)
      chk("R8 flags set", int'(flags), 3);
      chk("R8 irq masked", int'(irq), 0);
      irq_mask = 2'b10; @(negedge clk);
      chk("R8 irq cmd unmasked", int'(irq), 1);
      irq_mask = 2'b01; @(negedge clk);
      chk("R8 irq rd unmasked", int'(irq), 1);
      flag_clr = 2'b01; @(negedge clk); flag_clr = 2'b00; @(negedge clk);
      chk("R8 clear cmd flag", int'(flags), 2);
      flag_clr = 2'b10; @(negedge clk); flag_clr = 2'b00; @(negedge clk);
      chk("R8 clear rd flag", int'(flags), 0);
      chk("R8 irq idle", int'(irq), 0);
      irq_mask = 2'b00;

      // R2 other timing mixes
      cfg_setup = 4'd0; cfg_pulse = 4'd0; cfg_hold = 4'd3;
      run_cmd(12'h2E7, busy, wr, rd, frm, a0s, ds);
      chk("R2 busy s0 p0 h3", busy, 6);
      chk("R2 strobe s0 p0 h3", wr, 1);
      cfg_setup = 4'd3; cfg_pulse = 4'd1; cfg_hold = 4'd1;
      run_cmd(12'h381, busy, wr, rd, frm, a0s, ds);
      chk("R2 busy s3 p1 h1", busy, 8);
      chk("R2 strobe s3 p1 h1", wr, 2);
      chk("R1 dout second mix", int'(ds), 8'h81);
      cfg_setup = 4'd1; cfg_pulse = 4'd2; cfg_hold = 4'd0;

      // R4 continue flag: next word waiting during read
      bus_din = 8'hA5;
      @(negedge clk); cmd_valid = 1'b1; cmd_word = 12'h000;
      @(posedge clk);
      @(negedge clk); cmd_word = 12'h800;
      while (!cmd_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk); cmd_valid = 1'b0;
      chk("R4 continue set", int'(rd_status), 11'h6A5);
      flag_clr = 2'b11; @(negedge clk); flag_clr = 2'b00;

      // R10 word offered while busy is ignored
      @(negedge clk); cmd_valid = 1'b1; cmd_word = 12'h2AA;
      @(posedge clk);
      @(negedge clk); cmd_valid = 1'b0;
      @(negedge clk); cmd_valid = 1'b1; cmd_word = 12'hA00;
      chk("R10 ready low while busy", int'(cmd_ready), 0);
      @(negedge clk);
      @(negedge clk); cmd_valid = 1'b0;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      chk("R10 busy word dropped", int'(flags), 0);
      chk("R10 irq quiet", int'(irq), 0);

      // R6 vsync wait entered with vsync low
      vsync = 1'b0;
      @(negedge clk); cmd_valid = 1'b1; cmd_word = 12'h600;
      @(posedge clk);
      @(negedge clk); cmd_valid = 1'b0;
      cnt = 0;
      for (int k = 0; k < 20; k++) begin
         if (cmd_ready) cnt++;
         @(negedge clk);
      end
      chk("R6 stalls without vsync", cnt, 0);
      vsync = 1'b1;
      cnt = 0;
      while (!cmd_ready && cnt < 50) begin @(negedge clk); cnt++; end
      chk("R6 release latency", cnt, 3);

      // R6 vsync already high at acceptance
      @(negedge clk); cmd_valid = 1'b1; cmd_word = 12'h600;
      @(posedge clk);
      @(negedge clk); cmd_valid = 1'b0;
      cnt = 0;
      for (int k = 0; k < 10; k++) begin
         if (cmd_ready) cnt++;
         @(negedge clk);
      end
      chk("R6 high level not an edge", cnt, 0);
      vsync = 1'b0;
      repeat (4) @(negedge clk);
      vsync = 1'b1;
      cnt = 0;
      while (!cmd_ready && cnt < 50) begin @(negedge clk); cnt++; end
      chk("R6 second edge release", cnt, 3);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule